// File: doc/BRIEF.md
# Shift-and-add address generation unit

This unit computes the addresses that indexed array accesses need: a base operand plus an index operand scaled by 1, 2, 4 or 8. The index can be used at full register width, or as an unsigned 32-bit value taken from the low word of the index operand. A separate operation zero-extends that low word and shifts it left by an immediate amount, with no base added. The unit is a purely combinational slice of an execution stage. Decode hands it a 3-bit operation select, two register operands and a 6-bit immediate. It returns one result and a flag for operations that the current build does not support.

The register width `XLEN` is a parameter and may be 32 or 64. Every operation that works on the unsigned low word exists only in the 64-bit build. In the 32-bit build those encodings give a zero result and raise the illegal flag. No operand value is invalid, no exception is produced, and sums wrap modulo 2^XLEN with no carry-out.

Top module: `aagu_shadd_unit`

## Requirements
- R1: Operation codes 0, 1 and 2 return `rs2_i + (rs1_i << N)` for N = 1, 2 and 3. Both operands are used at full XLEN width, bits shifted above XLEN-1 are lost, and the sum wraps modulo 2^XLEN.
- R2: In the 64-bit build, operation code 3 returns `rs2_i` plus the value of `rs1_i[31:0]` zero-extended to 64 bits. The upper 32 bits of `rs1_i` have no effect on the result.
- R3: In the 64-bit build, operation codes 4, 5 and 6 zero-extend `rs1_i[31:0]`, shift it left by N = 1, 2 and 3, and add `rs2_i`, wrapping modulo 2^64.
- R4: In the 64-bit build, operation code 7 returns `rs1_i[31:0]`, zero-extended and shifted left by `imm_i[5:0]` (0 to 63). Bits shifted past bit 63 are discarded, and `rs2_i` has no effect on the result.
- R5: In the 32-bit build, operation codes 3 to 7 drive `result_o` to zero and `illegal_o` to 1.
- R6: `illegal_o` is 0 for operation codes 0 to 2 in both builds, and for every operation code in the 64-bit build. With all inputs zero, the result is zero.
- R7: `imm_i` has no effect on the result of operation codes 0 to 6. The result follows the current inputs with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation select, codes 0 to 7 as listed in the requirements |
| rs1_i | input | XLEN | Index operand, shifted and optionally reduced to its low word |
| rs2_i | input | XLEN | Base operand added to the scaled index |
| imm_i | input | 6 | Shift amount used by operation code 7 only |
| result_o | output | XLEN | Computed address or shifted word |
| illegal_o | output | 1 | High when the selected operation is absent from this build |

## Verification
The unit holds no state, so a wrong internal control value shows at the ports in the same evaluation as the input that caused it. A wrong shift amount moves the index part of the sum by a power of two. A missing zero-extension leaks bits 63..32 of `rs1_i` into the sum, which shows up once those bits are non-zero. A base that is wrongly gated shows up as soon as `rs2_i` is non-zero. The bench therefore drives large upper halves, all-ones and top-bit-set operands, and immediates at 0, 31, 32 and 63, so that each of these faults changes the result of the vector that applies it.

// File: rtl/aagu_pkg.sv
// Package for the shift-and-add address generation unit.
// Holds the operation encoding and the control word passed from the
// decoder to the datapath. Assumes a 3-bit operation select.
package aagu_pkg;

    localparam int OP_W   = 3;
    localparam int IMM_W  = 6;
    localparam int WORD_W = 32;

    typedef enum logic [OP_W-1:0] {
        OP_SH1ADD    = 3'd0,
        OP_SH2ADD    = 3'd1,
        OP_SH3ADD    = 3'd2,
        OP_ADD_UW    = 3'd3,
        OP_SH1ADD_UW = 3'd4,
        OP_SH2ADD_UW = 3'd5,
        OP_SH3ADD_UW = 3'd6,
        OP_SLLI_UW   = 3'd7
    } aagu_op_e;

    // Control decoded from the operation select
    typedef struct packed {
        logic       word_src;   // index taken from zero-extended low word
        logic       imm_shift;  // shift amount from the immediate, no base added
        logic [1:0] fixed_amt;  // fixed shift amount 0..3
    } aagu_ctl_t;

endpackage

// File: rtl/aagu_decode.sv
// Operation decoder for the address generation unit.
// Turns the operation select into datapath controls and flags any
// low-word operation as illegal when XLEN is not 64.
// Assumes XLEN is 32 or 64; purely combinational.
module aagu_decode
    import aagu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [OP_W-1:0] op_i,
    output aagu_ctl_t       ctl_o,
    output logic            illegal_o
);

    localparam bit WIDE = (XLEN == 64);

    aagu_op_e op;
    assign op = aagu_op_e'(op_i);

    // Map each operation to its source kind and shift amount
    always_comb begin
        ctl_o = '{word_src: 1'b0, imm_shift: 1'b0, fixed_amt: 2'd0};
        unique case (op)
            OP_SH1ADD:    ctl_o.fixed_amt = 2'd1;
            OP_SH2ADD:    ctl_o.fixed_amt = 2'd2;
            OP_SH3ADD:    ctl_o.fixed_amt = 2'd3;
            OP_ADD_UW:    ctl_o.word_src  = 1'b1;
            OP_SH1ADD_UW: begin ctl_o.word_src = 1'b1; ctl_o.fixed_amt = 2'd1; end
            OP_SH2ADD_UW: begin ctl_o.word_src = 1'b1; ctl_o.fixed_amt = 2'd2; end
            OP_SH3ADD_UW: begin ctl_o.word_src = 1'b1; ctl_o.fixed_amt = 2'd3; end
            OP_SLLI_UW:   begin ctl_o.word_src = 1'b1; ctl_o.imm_shift = 1'b1; end
            default:      ctl_o.fixed_amt = 2'd0;
        endcase
    end

    // Legality depends on the build width
    generate
        if (WIDE) begin : g_wide_legal
            assign illegal_o = 1'b0;
        end else begin : g_narrow_legal
            assign illegal_o = ctl_o.word_src;
        end
    endgenerate

    // Plain scaled adds always shift by 1..3 and use the full operand
    always_comb begin
        if (!$isunknown(op_i) && (op_i <= 3'd2)) begin
            assert_plain_scale_R1: assert (!ctl_o.word_src && !ctl_o.imm_shift && ctl_o.fixed_amt == op_i[1:0] + 2'd1)
                else $error("plain scaled add decoded wrongly");
        end
    end

endmodule

// File: rtl/aagu_operand_prep.sv
// Index operand preparation: passes rs1 through at full width or
// zero-extends its low 32-bit word. In a 32-bit build the two are the
// same value. Assumes XLEN >= 32; purely combinational.
module aagu_operand_prep
    import aagu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rs1_i,
    input  logic            word_src_i,
    output logic [XLEN-1:0] index_o
);

    localparam int HI_W = XLEN - WORD_W;

    generate
        if (HI_W > 0) begin : g_zext
            // Clear the upper part when the low word is selected
            always_comb begin
                index_o = rs1_i;
                if (word_src_i) index_o[XLEN-1:WORD_W] = '0;
            end
            // Zero-extended index carries no upper bits
            always_comb begin
                if (!$isunknown(word_src_i) && word_src_i) begin
                    assert_upper_clear_R2: assert (index_o[XLEN-1:WORD_W] == '0)
                        else $error("word index has upper bits set");
                end
            end
        end else begin : g_pass
            logic unused_sel;
            assign unused_sel = word_src_i;
            // Full width and word width coincide
            assign index_o = rs1_i;
        end
    endgenerate

endmodule

// File: rtl/aagu_shifter.sv
// Left shifter for the index operand. One barrel shifter serves both
// the fixed 0..3 scale and the 6-bit immediate amount. Bits leaving
// the top are dropped. Assumes AMT_W bits suffice for the amount.
module aagu_shifter #(
    parameter int XLEN  = 64,
    parameter int AMT_W = 6
) (
    input  logic [XLEN-1:0]  data_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [XLEN-1:0]  data_o
);

    localparam int STAGES = AMT_W;

    logic [XLEN-1:0] stage [STAGES+1];

    assign stage[0] = data_i;

    // One conditional power-of-two shift per amount bit
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            localparam int DIST = 1 << s;
            if (DIST < XLEN) begin : g_move
                assign stage[s+1] = amt_i[s] ? {stage[s][XLEN-1-DIST:0], {DIST{1'b0}}} : stage[s];
            end else begin : g_flush
                assign stage[s+1] = amt_i[s] ? '0 : stage[s];
            end
        end
    endgenerate

    assign data_o = stage[STAGES];

endmodule

// File: rtl/aagu_adder.sv
// Wrapping adder: adds the base to the shifted index, or passes the
// shifted index alone when the base is gated off. No carry-out.
module aagu_adder #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] index_i,
    input  logic [XLEN-1:0] base_i,
    input  logic            base_en_i,
    output logic [XLEN-1:0] sum_o
);

    logic [XLEN-1:0] base_gated;

    // Gate the base off for the immediate-shift operation
    assign base_gated = base_en_i ? base_i : '0;

    // Sum modulo 2^XLEN
    assign sum_o = index_i + base_gated;

endmodule

// File: rtl/aagu_shadd_unit.sv
// Top of the shift-and-add address generation unit. Decodes the
// operation, prepares the index, shifts it by a fixed or immediate
// amount and adds the base. Forces a zero result on an illegal op.
// Assumes XLEN is 32 or 64; purely combinational, no state.
module aagu_shadd_unit
    import aagu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [XLEN-1:0]  rs1_i,
    input  logic [XLEN-1:0]  rs2_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [XLEN-1:0]  result_o,
    output logic             illegal_o
);

    aagu_ctl_t        ctl;
    logic             illegal;
    logic [XLEN-1:0]  index;
    logic [XLEN-1:0]  shifted;
    logic [IMM_W-1:0] amt;
    logic [XLEN-1:0]  sum;

    initial begin
        assert_xlen_legal_R6: assert (XLEN == 32 || XLEN == 64)
            else $error("XLEN must be 32 or 64");
    end

    aagu_decode #(.XLEN(XLEN)) u_decode (
        .op_i      (op_i),
        .ctl_o     (ctl),
        .illegal_o (illegal)
    );

    aagu_operand_prep #(.XLEN(XLEN)) u_prep (
        .rs1_i      (rs1_i),
        .word_src_i (ctl.word_src),
        .index_o    (index)
    );

    // Pick the immediate or the fixed scale as the shift amount
    assign amt = ctl.imm_shift ? imm_i : {{(IMM_W-2){1'b0}}, ctl.fixed_amt};

    aagu_shifter #(.XLEN(XLEN), .AMT_W(IMM_W)) u_shift (
        .data_i (index),
        .amt_i  (amt),
        .data_o (shifted)
    );

    aagu_adder #(.XLEN(XLEN)) u_add (
        .index_i   (shifted),
        .base_i    (rs2_i),
        .base_en_i (!ctl.imm_shift),
        .sum_o     (sum)
    );

    // Drive outputs, zero result on an unsupported operation
    assign result_o  = illegal ? '0 : sum;
    assign illegal_o = illegal;

    // Output-level checks beside the result mux
    always_comb begin
        if (!$isunknown({op_i, imm_i, rs1_i, rs2_i})) begin
            assert_illegal_quiet_R5: assert (!illegal_o || result_o == '0)
                else $error("illegal op produced a non-zero result");
            assert_wide_all_legal_R6: assert (XLEN != 64 || !illegal_o)
                else $error("64-bit build flagged an op illegal");
            assert_plain_legal_R6: assert (op_i > 3'd2 || !illegal_o)
                else $error("plain scaled add flagged illegal");
            if (op_i == 3'd7 && !illegal_o) begin
                assert_slli_low_zero_R4: assert ((result_o & ((XLEN'(1) << imm_i) - XLEN'(1))) == '0)
                    else $error("shifted word has low bits set");
            end
        end
    end

endmodule

// File: tb/aagu_shadd_unit_tb.sv
// Directed bench: a 64-bit and a 32-bit instance share the operands;
// each task drives one scenario and checks against values computed here.
module aagu_shadd_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [5:0]  imm;
    logic [63:0] res_w;
    logic        ill_w;
    logic [31:0] res_n;
    logic        ill_n;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aagu_shadd_unit #(.XLEN(64)) u_dut (
        .op_i(op), .rs1_i(a), .rs2_i(b), .imm_i(imm),
        .result_o(res_w), .illegal_o(ill_w)
    );

    aagu_shadd_unit #(.XLEN(32)) u_dut_narrow (
        .op_i(op), .rs1_i(a[31:0]), .rs2_i(b[31:0]), .imm_i(imm),
        .result_o(res_n), .illegal_o(ill_n)
    );

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    function automatic logic [63:0] ref_wide(logic [2:0] o, logic [63:0] x, logic [63:0] y, logic [5:0] s);
        logic [63:0] zx;
        zx = {32'd0, x[31:0]};
        case (o)
            3'd0: return y + (x << 1);
            3'd1: return y + (x << 2);
            3'd2: return y + (x << 3);
            3'd3: return y + zx;
            3'd4: return y + (zx << 1);
            3'd5: return y + (zx << 2);
            3'd6: return y + (zx << 3);
            default: return zx << s;
        endcase
    endfunction

    function automatic logic [31:0] ref_narrow(logic [2:0] o, logic [31:0] x, logic [31:0] y);
        case (o)
            3'd0: return y + (x << 1);
            3'd1: return y + (x << 2);
            3'd2: return y + (x << 3);
            default: return 32'd0;
        endcase
    endfunction

    task automatic drive(logic [2:0] o, logic [63:0] x, logic [63:0] y, logic [5:0] s);
        @(negedge clk);
        op = o; a = x; b = y; imm = s;
        #(CLK_PERIOD/4);
    endtask

    task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s op=%0d actual=%h expected=%h", req, op, act, exp);
        end
    endtask

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s op=%0d actual=%h expected=%h", req, op, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s op=%0d actual=%b expected=%b", req, op, act, exp);
        end
    endtask

    // R6: all-zero inputs give zero and no illegal flag
    task automatic test_idle();
        drive(3'd0, 64'd0, 64'd0, 6'd0);
        check64("R6", res_w, 64'd0);
        check32("R6", res_n, 32'd0);
        check_bit("R6", ill_w, 1'b0);
        check_bit("R6", ill_n, 1'b0);
    endtask

    // R1: plain scaled adds, corners and random, both widths
    task automatic test_plain();
        logic [63:0] corners [4] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_8000_0000,
                                     64'h0000_0001_0000_0001, 64'hE000_0000_E000_0001};
        for (int o = 0; o < 3; o++) begin
            for (int c = 0; c < 4; c++) begin
                drive(3'(o), corners[c], corners[3-c], 6'(c));
                check64("R1", res_w, ref_wide(3'(o), a, b, imm));
                check32("R1", res_n, ref_narrow(3'(o), a[31:0], b[31:0]));
                check_bit("R6", ill_n, 1'b0);
            end
            for (int k = 0; k < 40; k++) begin
                drive(3'(o), rnd64(), rnd64(), 6'($urandom));
                check64("R1", res_w, ref_wide(3'(o), a, b, imm));
                check32("R1", res_n, ref_narrow(3'(o), a[31:0], b[31:0]));
            end
        end
    endtask

    // R2: upper half of rs1 must not reach the sum
    task automatic test_add_word();
        drive(3'd3, 64'hDEAD_BEEF_0000_0010, 64'h0000_0000_0000_1000, 6'd0);
        check64("R2", res_w, 64'h0000_0000_0000_1010);
        drive(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, 6'd0);
        check64("R2", res_w, 64'h0000_0000_0000_0000);
        for (int k = 0; k < 40; k++) begin
            drive(3'd3, rnd64(), rnd64(), 6'($urandom));
            check64("R2", res_w, ref_wide(3'd3, a, b, imm));
            check_bit("R6", ill_w, 1'b0);
        end
    endtask

    // R3: scaled low-word adds
    task automatic test_scaled_word();
        drive(3'd6, 64'h1234_5678_FFFF_FFFF, 64'd8, 6'd0);
        check64("R3", res_w, 64'h0000_0007_FFFF_FFF8 + 64'd8);
        for (int o = 4; o < 7; o++) begin
            for (int k = 0; k < 40; k++) begin
                drive(3'(o), rnd64(), rnd64(), 6'($urandom));
                check64("R3", res_w, ref_wide(3'(o), a, b, imm));
            end
        end
    endtask

    // R4: immediate shift of the low word, base ignored
    task automatic test_imm_shift();
        logic [5:0] amts [5] = '{6'd0, 6'd31, 6'd32, 6'd33, 6'd63};
        for (int i = 0; i < 5; i++) begin
            drive(3'd7, 64'hABCD_EF01_8000_0003, 64'hFFFF_FFFF_FFFF_FFFF, amts[i]);
            check64("R4", res_w, ({32'd0, 32'h8000_0003} << amts[i]));
        end
        drive(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd63);
        check64("R4", res_w, 64'h8000_0000_0000_0000);
        for (int k = 0; k < 40; k++) begin
            drive(3'd7, rnd64(), rnd64(), 6'($urandom));
            check64("R4", res_w, ref_wide(3'd7, a, b, imm));
        end
    endtask

    // R5: 32-bit build rejects word operations
    task automatic test_narrow_illegal();
        for (int o = 3; o < 8; o++) begin
            drive(3'(o), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7FFF_FFFF, 6'd5);
            check32("R5", res_n, 32'd0);
            check_bit("R5", ill_n, 1'b1);
            check_bit("R6", ill_w, 1'b0);
        end
    endtask

    // R7: immediate has no effect on ops 0..6
    task automatic test_imm_ignored();
        logic [63:0] x, y, first_w;
        logic [31:0] first_n;
        for (int o = 0; o < 7; o++) begin
            x = rnd64(); y = rnd64();
            drive(3'(o), x, y, 6'd0);
            first_w = res_w; first_n = res_n;
            check64("R7", first_w, ref_wide(3'(o), x, y, 6'd0));
            drive(3'(o), x, y, 6'd63);
            check64("R7", res_w, first_w);
            check32("R7", res_n, first_n);
            drive(3'(o), x, y, 6'd17);
            check64("R7", res_w, first_w);
        end
    endtask

    initial begin
        op = '0; a = '0; b = '0; imm = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        test_idle();
        test_plain();
        test_add_word();
        test_scaled_word();
        test_imm_shift();
        test_narrow_illegal();
        test_imm_ignored();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule